// File: doc/BRIEF.md
# PCIe Root Outbound Window Decoder

This block is the address-map half of a PCI Express root port's host bridge. Software programs it through a small bank of 32-bit control words. The bank holds 64-bit bases for the configuration, message and register spaces, and for three outbound memory windows. Each window has its own mask. The block derives the size of the configuration window and of the register window from their mask words. For every 64-bit processor address presented on the lookup strobe, it reports one cycle later which outbound window claims the address and the offset within it.

A 64-bit value is always written as two independent 32-bit halves. A mask word carries its window's enable in bit 0. A window's size is the two's complement of the mask with bit 0 cleared. The configuration window is clamped to 256 MiB. The register-space mask value 0x7001 is a special code for a 4 KiB window.

The lookup path is a two-state machine, `ST_IDLE` and `ST_PRESENT`:
- `in_valid` high moves the machine to `ST_PRESENT` (transition "strobe seen").
- `in_valid` low returns it to `ST_IDLE` (transition "no strobe").
- `hit_valid` is high exactly while the machine is in `ST_PRESENT`.

Top module: `pcie_obwin_decoder`

## Requirements
- R1: The control words sit at these word offsets on `reg_addr`:
  - 0: configuration base, high half. 1: configuration base, low half. 2: configuration mask.
  - 3: message base, high half. 4: message base, low half. 5: message mask.
  - 8+4w to 11+4w for window w (w = 0..2, the windows numbered 1..3): base high, base low, mask high, mask low, in that order.
  - 20: register-space base, high half. 21: register-space base, low half. 22: register-space mask.
  
  A write (`reg_wr` high at a clock edge) updates only the addressed 32-bit word. `reg_rdata` shows the word at `reg_addr` combinationally.
- R2: `cfg_win_en` equals bit 0 of the configuration mask. `cfg_win_size` is the 32-bit value (~(mask & 0xFFFFFFFE)) + 1.
- R3: A configuration size above 0x1000_0000 (256 MiB) is replaced by 0x1000_0000. For example, a mask of 0xE0000001 gives 0x1000_0000.
- R4: `reg_win_size` is 4096 when the register-space mask is exactly 0x7001. Otherwise it follows the two's-complement rule of R2, with no clamp.
- R5: Offsets 6, 7 and 23..31 read as zero. Writes to them change no readable word.
- R6: Window w hits an address A when bit 0 of its 64-bit mask M is set and (A & M) == (B & M), where B is its 64-bit base.
- R7: When several windows hit, the one with the lowest number wins. `hit_sel` bit w marks window w.
- R8: `hit_valid` is high for exactly the one cycle after each clock edge at which `in_valid` was high. During that cycle:
  - On a hit, `hit_sel` is one-hot and `hit_off` = A & ~M of the winning window.
  - On a miss, both `hit_sel` and `hit_off` are zero.
  - Both values hold until the next strobe.
- R9: Reset clears every base and mask. All words then read zero, every window is disabled and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_addr | input | 5 | Control word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| in_valid | input | 1 | Lookup strobe |
| in_addr | input | 64 | Processor address to decode |
| hit_valid | output | 1 | Lookup result valid |
| hit_sel | output | 3 | One-hot winning window, zero on miss |
| hit_off | output | 64 | Offset within the winning window |
| cfg_win_en | output | 1 | Configuration window enable |
| cfg_win_size | output | 32 | Clamped configuration window size |
| reg_win_size | output | 32 | Register-space window size |

## Verification
The bench builds the block with its defaults: three windows, a 5-bit word offset, a 256 MiB configuration clamp and the 0x7001 special code. Three windows are enough to exercise a priority chain with both a head and a middle element. The 5-bit offset brings the unmapped words on both sides of the window bank within reach. The random masks span 4 KiB to 1 TiB windows with random enable bits and overlapping bases. This makes multi-window hits, disabled-window fall-through and enable-bit address mismatches frequent, alongside directed clamp-edge and special-code cases.

// File: rtl/pcie_obwin_pkg.sv
package pcie_obwin_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } look_state_e;

    // word offsets of the fixed control words
    localparam int OFF_CFG_BH  = 0;
    localparam int OFF_CFG_BL  = 1;
    localparam int OFF_CFG_MSK = 2;
    localparam int OFF_MSG_BH  = 3;
    localparam int OFF_MSG_BL  = 4;
    localparam int OFF_MSG_MSK = 5;
    localparam int OFF_WIN0    = 8;
    localparam int WIN_STRIDE  = 4;

    // size encoded by a mask word: two's complement with the enable bit cleared
    function automatic logic [31:0] mask_to_size(input logic [31:0] m);
        return (~(m & 32'hFFFF_FFFE)) + 32'h1;
    endfunction

endpackage

// File: rtl/obw_regfile.sv
module obw_regfile
    import pcie_obwin_pkg::*;
#(
    parameter int NWIN = 3,
    parameter int RAW  = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [RAW-1:0]             addr,
    input  logic [31:0]                wdata,
    output logic [31:0]                rdata,
    output logic [31:0]                cfg_mask,
    output logic [31:0]                reg_mask,
    output logic [NWIN-1:0][63:0]      win_base,
    output logic [NWIN-1:0][63:0]      win_mask
);

    localparam int OFF_REG_BH  = OFF_WIN0 + WIN_STRIDE * NWIN;
    localparam int OFF_REG_BL  = OFF_REG_BH + 1;
    localparam int OFF_REG_MSK = OFF_REG_BH + 2;

    localparam logic [RAW-1:0] A_CFG_BH  = RAW'(OFF_CFG_BH);
    localparam logic [RAW-1:0] A_CFG_BL  = RAW'(OFF_CFG_BL);
    localparam logic [RAW-1:0] A_CFG_MSK = RAW'(OFF_CFG_MSK);
    localparam logic [RAW-1:0] A_MSG_BH  = RAW'(OFF_MSG_BH);
    localparam logic [RAW-1:0] A_MSG_BL  = RAW'(OFF_MSG_BL);
    localparam logic [RAW-1:0] A_MSG_MSK = RAW'(OFF_MSG_MSK);
    localparam logic [RAW-1:0] A_REG_BH  = RAW'(OFF_REG_BH);
    localparam logic [RAW-1:0] A_REG_BL  = RAW'(OFF_REG_BL);
    localparam logic [RAW-1:0] A_REG_MSK = RAW'(OFF_REG_MSK);

    logic [63:0] cfg_base_q;
    logic [63:0] msg_base_q;
    logic [63:0] reg_base_q;
    logic [31:0] cfg_mask_q;
    logic [31:0] msg_mask_q;
    logic [31:0] reg_mask_q;

    // fixed spaces: each half has its own write select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_base_q <= '0;
            msg_base_q <= '0;
            reg_base_q <= '0;
            cfg_mask_q <= '0;
            msg_mask_q <= '0;
            reg_mask_q <= '0;
        end else if (wr) begin
            if (addr == A_CFG_BH)  cfg_base_q[63:32] <= wdata;
            if (addr == A_CFG_BL)  cfg_base_q[31:0]  <= wdata;
            if (addr == A_CFG_MSK) cfg_mask_q        <= wdata;
            if (addr == A_MSG_BH)  msg_base_q[63:32] <= wdata;
            if (addr == A_MSG_BL)  msg_base_q[31:0]  <= wdata;
            if (addr == A_MSG_MSK) msg_mask_q        <= wdata;
            if (addr == A_REG_BH)  reg_base_q[63:32] <= wdata;
            if (addr == A_REG_BL)  reg_base_q[31:0]  <= wdata;
            if (addr == A_REG_MSK) reg_mask_q        <= wdata;
        end
    end

    // outbound windows: one register group per window
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam logic [RAW-1:0] A_BH = RAW'(OFF_WIN0 + WIN_STRIDE * g);
        localparam logic [RAW-1:0] A_BL = RAW'(OFF_WIN0 + WIN_STRIDE * g + 1);
        localparam logic [RAW-1:0] A_MH = RAW'(OFF_WIN0 + WIN_STRIDE * g + 2);
        localparam logic [RAW-1:0] A_ML = RAW'(OFF_WIN0 + WIN_STRIDE * g + 3);

        logic [63:0] base_q;
        logic [63:0] mask_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                mask_q <= '0;
            end else if (wr) begin
                if (addr == A_BH) base_q[63:32] <= wdata;
                if (addr == A_BL) base_q[31:0]  <= wdata;
                if (addr == A_MH) mask_q[63:32] <= wdata;
                if (addr == A_ML) mask_q[31:0]  <= wdata;
            end
        end

        assign win_base[g] = base_q;
        assign win_mask[g] = mask_q;
    end

    // readback; unmapped offsets stay zero
    always_comb begin
        rdata = '0;
        if (addr == A_CFG_BH)  rdata = cfg_base_q[63:32];
        if (addr == A_CFG_BL)  rdata = cfg_base_q[31:0];
        if (addr == A_CFG_MSK) rdata = cfg_mask_q;
        if (addr == A_MSG_BH)  rdata = msg_base_q[63:32];
        if (addr == A_MSG_BL)  rdata = msg_base_q[31:0];
        if (addr == A_MSG_MSK) rdata = msg_mask_q;
        if (addr == A_REG_BH)  rdata = reg_base_q[63:32];
        if (addr == A_REG_BL)  rdata = reg_base_q[31:0];
        if (addr == A_REG_MSK) rdata = reg_mask_q;
        for (int w = 0; w < NWIN; w++) begin
            if (addr == RAW'(OFF_WIN0 + WIN_STRIDE * w))     rdata = win_base[w][63:32];
            if (addr == RAW'(OFF_WIN0 + WIN_STRIDE * w + 1)) rdata = win_base[w][31:0];
            if (addr == RAW'(OFF_WIN0 + WIN_STRIDE * w + 2)) rdata = win_mask[w][63:32];
            if (addr == RAW'(OFF_WIN0 + WIN_STRIDE * w + 3)) rdata = win_mask[w][31:0];
        end
    end

    assign cfg_mask = cfg_mask_q;
    assign reg_mask = reg_mask_q;

endmodule

// File: rtl/obw_size_calc.sv
module obw_size_calc
    import pcie_obwin_pkg::*;
#(
    parameter logic [31:0] CFG_MAX_SIZE     = 32'h1000_0000,
    parameter logic [31:0] REG_SPECIAL_MASK = 32'h0000_7001,
    parameter logic [31:0] REG_SPECIAL_SIZE = 32'd4096
) (
    input  logic [31:0] cfg_mask,
    input  logic [31:0] reg_mask,
    output logic        cfg_en,
    output logic [31:0] cfg_size,
    output logic [31:0] reg_size
);

    logic [31:0] cfg_raw;

    always_comb begin
        cfg_raw  = mask_to_size(cfg_mask);
        cfg_en   = cfg_mask[0];
        cfg_size = (cfg_raw > CFG_MAX_SIZE) ? CFG_MAX_SIZE : cfg_raw;
        reg_size = (reg_mask == REG_SPECIAL_MASK) ? REG_SPECIAL_SIZE
                                                  : mask_to_size(reg_mask);
    end

endmodule

// File: rtl/obw_window_match.sv
module obw_window_match #(
    parameter int NWIN = 3
) (
    input  logic [63:0]               addr,
    input  logic [NWIN-1:0][63:0]     win_base,
    input  logic [NWIN-1:0][63:0]     win_mask,
    output logic [NWIN-1:0]           hit_vec,
    output logic [NWIN-1:0][63:0]     off_vec
);

    for (genvar g = 0; g < NWIN; g++) begin : g_cmp
        assign hit_vec[g] = win_mask[g][0] &&
                            ((addr & win_mask[g]) == (win_base[g] & win_mask[g]));
        assign off_vec[g] = addr & ~win_mask[g];
    end

endmodule

// File: rtl/obw_hit_pipe.sv
module obw_hit_pipe
    import pcie_obwin_pkg::*;
#(
    parameter int NWIN = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [NWIN-1:0]           hit_vec,
    input  logic [NWIN-1:0][63:0]     off_vec,
    output logic                      hit_valid,
    output logic [NWIN-1:0]           hit_sel,
    output logic [63:0]               hit_off
);

    look_state_e state_q, state_d;
    logic [NWIN-1:0] sel_d;
    logic [63:0]     off_d;

    // lowest-numbered hitting window wins: scan from the top down
    always_comb begin
        sel_d = '0;
        off_d = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                sel_d    = '0;
                sel_d[w] = 1'b1;
                off_d    = off_vec[w];
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:    state_d = in_valid ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: state_d = in_valid ? ST_PRESENT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_sel <= '0;
            hit_off <= '0;
        end else if (in_valid) begin
            hit_sel <= sel_d;
            hit_off <= off_d;
        end
    end

    assign hit_valid = (state_q == ST_PRESENT);

endmodule

// File: rtl/pcie_obwin_decoder.sv
module pcie_obwin_decoder
    import pcie_obwin_pkg::*;
#(
    parameter int          NWIN             = 3,
    parameter int          RAW              = 5,
    parameter logic [31:0] CFG_MAX_SIZE     = 32'h1000_0000,
    parameter logic [31:0] REG_SPECIAL_MASK = 32'h0000_7001,
    parameter logic [31:0] REG_SPECIAL_SIZE = 32'd4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [RAW-1:0]   reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             in_valid,
    input  logic [63:0]      in_addr,
    output logic             hit_valid,
    output logic [NWIN-1:0]  hit_sel,
    output logic [63:0]      hit_off,
    output logic             cfg_win_en,
    output logic [31:0]      cfg_win_size,
    output logic [31:0]      reg_win_size
);

    logic [31:0]            cfg_mask;
    logic [31:0]            reg_mask;
    logic [NWIN-1:0][63:0]  win_base;
    logic [NWIN-1:0][63:0]  win_mask;
    logic [NWIN-1:0]        hit_vec;
    logic [NWIN-1:0][63:0]  off_vec;

    obw_regfile #(.NWIN(NWIN), .RAW(RAW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cfg_mask (cfg_mask),
        .reg_mask (reg_mask),
        .win_base (win_base),
        .win_mask (win_mask)
    );

    obw_size_calc #(
        .CFG_MAX_SIZE     (CFG_MAX_SIZE),
        .REG_SPECIAL_MASK (REG_SPECIAL_MASK),
        .REG_SPECIAL_SIZE (REG_SPECIAL_SIZE)
    ) u_size (
        .cfg_mask (cfg_mask),
        .reg_mask (reg_mask),
        .cfg_en   (cfg_win_en),
        .cfg_size (cfg_win_size),
        .reg_size (reg_win_size)
    );

    obw_window_match #(.NWIN(NWIN)) u_match (
        .addr     (in_addr),
        .win_base (win_base),
        .win_mask (win_mask),
        .hit_vec  (hit_vec),
        .off_vec  (off_vec)
    );

    obw_hit_pipe #(.NWIN(NWIN)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .hit_vec   (hit_vec),
        .off_vec   (off_vec),
        .hit_valid (hit_valid),
        .hit_sel   (hit_sel),
        .hit_off   (hit_off)
    );

endmodule

// File: rtl/obw_checker.sv
module obw_checker
    import pcie_obwin_pkg::*;
#(
    parameter int          NWIN             = 3,
    parameter int          RAW              = 5,
    parameter logic [31:0] CFG_MAX_SIZE     = 32'h1000_0000,
    parameter logic [31:0] REG_SPECIAL_MASK = 32'h0000_7001,
    parameter logic [31:0] REG_SPECIAL_SIZE = 32'd4096
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [RAW-1:0]   reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             in_valid,
    input logic             hit_valid,
    input logic [NWIN-1:0]  hit_sel,
    input logic [63:0]      hit_off,
    input logic             cfg_win_en,
    input logic [31:0]      cfg_win_size,
    input logic [31:0]      reg_win_size
);

    localparam int OFF_LAST = OFF_WIN0 + WIN_STRIDE * NWIN + 2;

    logic unmapped;
    assign unmapped = ((int'(reg_addr) > OFF_MSG_MSK) && (int'(reg_addr) < OFF_WIN0)) ||
                      (int'(reg_addr) > OFF_LAST);

    p_cfg_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && int'(reg_addr) == OFF_CFG_MSK) |=> (cfg_win_en == $past(reg_wdata[0])));

    p_cfg_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_win_size <= CFG_MAX_SIZE);

    p_reg_special_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && int'(reg_addr) == OFF_LAST && reg_wdata == REG_SPECIAL_MASK)
        |=> (reg_win_size == REG_SPECIAL_SIZE));

    p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (reg_rdata == 32'h0));

    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> $onehot0(hit_sel));

    p_valid_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> hit_valid);

    p_valid_only_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !hit_valid);

    p_miss_zero_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_sel == '0) |-> (hit_off == 64'h0));

endmodule

bind pcie_obwin_decoder obw_checker #(
    .NWIN             (NWIN),
    .RAW              (RAW),
    .CFG_MAX_SIZE     (CFG_MAX_SIZE),
    .REG_SPECIAL_MASK (REG_SPECIAL_MASK),
    .REG_SPECIAL_SIZE (REG_SPECIAL_SIZE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .in_valid     (in_valid),
    .hit_valid    (hit_valid),
    .hit_sel      (hit_sel),
    .hit_off      (hit_off),
    .cfg_win_en   (cfg_win_en),
    .cfg_win_size (cfg_win_size),
    .reg_win_size (reg_win_size)
);

// File: tb/sim_pcie_obwin_decoder.sv
module sim_pcie_obwin_decoder;

    localparam int NW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          in_valid = 1'b0;
    logic [63:0]   in_addr = '0;
    logic          hit_valid;
    logic [NW-1:0] hit_sel;
    logic [63:0]   hit_off;
    logic          cfg_win_en;
    logic [31:0]   cfg_win_size;
    logic [31:0]   reg_win_size;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [31:0] mirror [32];

    always #4 clk = ~clk;

    pcie_obwin_decoder u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_addr(in_addr), .hit_valid(hit_valid), .hit_sel(hit_sel),
        .hit_off(hit_off), .cfg_win_en(cfg_win_en), .cfg_win_size(cfg_win_size),
        .reg_win_size(reg_win_size)
    );

    function automatic bit is_mapped(input int a);
        return (a <= 5) || (a >= 8 && a <= 22);
    endfunction

    function automatic logic [31:0] tc_size(input logic [31:0] m);
        return (~(m & 32'hFFFF_FFFE)) + 32'h1;
    endfunction

    function automatic logic [31:0] exp_cfg_size(input logic [31:0] m);
        logic [31:0] s = tc_size(m);
        return (s > 32'h1000_0000) ? 32'h1000_0000 : s;
    endfunction

    function automatic logic [31:0] exp_reg_size(input logic [31:0] m);
        return (m == 32'h7001) ? 32'd4096 : tc_size(m);
    endfunction

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (is_mapped(a)) mirror[a] = d;
    endtask

    task automatic rd_check(input string tag, input int a);
        @(negedge clk);
        reg_addr = 5'(a);
        #1;
        check64(tag, {32'h0, reg_rdata}, {32'h0, (is_mapped(a) ? mirror[a] : 32'h0)});
    endtask

    task automatic lookup(input string tag, input logic [63:0] a);
        logic [NW-1:0] es = '0;
        logic [63:0]   eo = '0;
        for (int w = NW - 1; w >= 0; w--) begin
            logic [63:0] b = {mirror[8 + 4*w], mirror[9 + 4*w]};
            logic [63:0] m = {mirror[10 + 4*w], mirror[11 + 4*w]};
            if (m[0] && ((a & m) == (b & m))) begin
                es = '0; es[w] = 1'b1; eo = a & ~m;
            end
        end
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        check64({tag, " R8 valid"}, {63'h0, hit_valid}, 64'h1);
        check64({tag, " R6/R7 sel"}, {61'h0, hit_sel}, {61'h0, es});
        check64({tag, " R8 off"}, hit_off, eo);
        @(negedge clk);
        check64({tag, " R8 pulse"}, {63'h0, hit_valid}, 64'h0);
        check64({tag, " R8 hold"}, {61'h0, hit_sel}, {61'h0, es});
    endtask

    task automatic sizes_check(input string tag);
        @(negedge clk);
        check64({tag, " R2 en"}, {63'h0, cfg_win_en}, {63'h0, mirror[2][0]});
        check64({tag, " R2/R3 cfg size"}, {32'h0, cfg_win_size}, {32'h0, exp_cfg_size(mirror[2])});
        check64({tag, " R4 reg size"}, {32'h0, reg_win_size}, {32'h0, exp_reg_size(mirror[22])});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < 32; i++) mirror[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        for (int a = 0; a < 32; a++) rd_check("R9 reset readback", a);
        sizes_check("R9 reset");
        lookup("R9 reset lookup", 64'h0);
        lookup("R9 reset lookup2", 64'hFFFF_FFFF_FFFF_FFFE);

        // R1: halves are independent
        wr(0, 32'h1234_5678);
        wr(1, 32'h9ABC_DEF0);
        rd_check("R1 cfg hi", 0);
        rd_check("R1 cfg lo", 1);
        wr(0, 32'h0BAD_F00D);
        rd_check("R1 lo untouched", 1);
        rd_check("R1 hi rewritten", 0);
        wr(13, 32'hAAAA_5555);
        rd_check("R1 win1 base lo", 13);
        rd_check("R1 win1 base hi", 12);

        // R2/R3: enable, two's complement, clamp edges
        wr(2, 32'hFFF0_0001); sizes_check("R2 1MiB");
        wr(2, 32'hE000_0001); sizes_check("R3 firmware clamp");
        check64("R3 clamp value", {32'h0, cfg_win_size}, 64'h1000_0000);
        wr(2, 32'hF000_0000); sizes_check("R3 exactly max, disabled");
        wr(2, 32'hEFFF_FFFF); sizes_check("R3 just above max");
        wr(2, 32'h0000_0001); sizes_check("R2 zero mask wraps");

        // R4: special code and neighbours
        wr(22, 32'h0000_7001); sizes_check("R4 special");
        check64("R4 special value", {32'h0, reg_win_size}, 64'd4096);
        wr(22, 32'h0000_7000); sizes_check("R4 near special");
        wr(22, 32'hFFFF_F001); sizes_check("R4 plain 4K");
        wr(22, 32'h8000_0001); sizes_check("R4 no clamp");

        // R5: unmapped offsets
        wr(6, 32'hDEAD_BEEF); wr(7, 32'h1111_1111);
        wr(23, 32'h2222_2222); wr(31, 32'hFFFF_FFFF);
        for (int a = 0; a < 32; a++) rd_check("R5 readback after unmapped writes", a);

        // R6/R7 directed: overlapping windows
        wr(8,  32'h0000_0001); wr(9,  32'h0000_0000);
        wr(10, 32'hFFFF_FFFF); wr(11, 32'hF000_0001);
        wr(12, 32'h0000_0001); wr(13, 32'h0000_0000);
        wr(14, 32'hFFFF_FFFF); wr(15, 32'h0000_0001);
        lookup("R7 both hit, window 1 wins", 64'h0000_0001_0123_4560);
        lookup("R6 only window 2", 64'h0000_0001_8000_0000);
        lookup("R6 enable-bit mismatch", 64'h0000_0001_0000_0011);
        wr(11, 32'hF000_0000);
        lookup("R6 disabled window skipped", 64'h0000_0001_0123_4560);
        lookup("R6 miss", 64'h0000_0002_0000_0000);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom % 4);
            if (op == 0) begin
                int w = int'($urandom % NW);
                int k = 12 + int'($urandom % 29);
                logic [63:0] m = (64'hFFFF_FFFF_FFFF_FFFF << k) | {63'h0, ($urandom % 4) != 0};
                logic [63:0] b = {$urandom, $urandom};
                wr(8 + 4*w, b[63:32]); wr(9 + 4*w, b[31:0]);
                wr(10 + 4*w, m[63:32]); wr(11 + 4*w, m[31:0]);
            end else if (op == 1) begin
                int a = int'($urandom % 32);
                wr(a, $urandom);
                rd_check("R1/R5 random readback", a);
                if (a == 2 || a == 22) sizes_check("R2/R4 random sizes");
            end else begin
                int w = int'($urandom % NW);
                logic [63:0] b = {mirror[8 + 4*w], mirror[9 + 4*w]};
                logic [63:0] m = {mirror[10 + 4*w], mirror[11 + 4*w]};
                logic [63:0] r = {$urandom, $urandom};
                logic [63:0] a = ($urandom % 2 == 0) ? ((b & m) | (r & ~m)) : r;
                lookup("R6/R7/R8 random", a);
            end
        end

        // R9: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 32; i++) mirror[i] = '0;
        for (int a = 0; a < 32; a++) rd_check("R9 second reset readback", a);
        lookup("R9 second reset lookup", 64'h0000_0001_0123_4560);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule